// File: doc/BRIEF.md
# Fixed-Reply I2C Target

This block is a target device on a two-wire I2C bus. It samples the SCL and SDA wires with the system clock through synchronizer flops and finds edges and bus conditions inside that clock domain. After a START, it collects an address byte. When the upper seven bits of that byte equal the configured address, it acknowledges. The lowest bit of the byte selects the direction.

When the controller writes, every data byte that arrives is sent out as a one-cycle valid pulse with its data. A configuration input selects whether data bytes are acknowledged or left unacknowledged. When the controller reads, the target returns the same configured byte each time it is asked. It continues until the controller declines a byte.

A configurable stretch length, counted in system clock cycles, makes the block pull SCL low after every SCL falling edge while a transaction is in progress. The block's own hold on SCL is kept out of edge detection. Both wires are driven only as open-drain enables.

Top module: `i2c_const_target`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe` and `rx_valid` are all 0.
- R2: SDA falling while SCL is high (START) restarts address collection from any state, including in the middle of a byte. SDA rising while SCL is high (STOP) returns the block to idle.
- R3: The address byte is shifted in MSB first on SCL rising edges. If its bits 7..1 equal `cfg_addr`, SDA is pulled low during the ninth clock. Otherwise SDA stays released for that clock, and the rest of the transfer is ignored up to the next START.
- R4: When bit 0 of the address byte is 0 (controller writes), each data byte is shifted in MSB first. It then appears on `rx_data` with `rx_valid` high for exactly one cycle, and bytes appear in bus order.
- R5: With `cfg_ack_data`=1, each written data byte is acknowledged (SDA low in its ninth clock). With `cfg_ack_data`=0, SDA stays released in that clock, and the byte is still delivered on the output stream.
- R6: When bit 0 of the address byte is 1 (controller reads), the target drives `cfg_reply` MSB first. Each bit is changed only after an SCL falling edge.
- R7: After a read byte, a controller ACK (SDA low) makes the target send `cfg_reply` again. A controller NACK (SDA high) returns it to idle with SDA released.
- R8: When `cfg_stretch` is N>0, `scl_oe` is held high for exactly N cycles after each SCL falling edge that occurs while a transaction is active. When N=0, `scl_oe` stays 0.
- R9: The block's own hold on SCL creates no extra SCL edges. With stretching active, transfers deliver the same bits, acknowledgements and bytes as without stretching.
- R10: While the block is idle (after reset, a STOP, an address mismatch or a controller NACK), neither `sda_oe` nor `scl_oe` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the SCL wire |
| sda_i | input | 1 | Level of the SDA wire |
| cfg_addr | input | 7 | Target address to match |
| cfg_reply | input | 8 | Byte returned on every read |
| cfg_ack_data | input | 1 | 1: acknowledge written data bytes; 0: leave them unacknowledged |
| cfg_stretch | input | STRETCH_W | SCL hold length in clock cycles; 0 disables |
| rx_valid | output | 1 | One-cycle pulse for a received data byte |
| rx_data | output | 8 | Received data byte |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong bit count or shift register shows up within one byte time. The symptoms are a misplaced acknowledge, a wrong byte on `rx_data`, or a corrupted reply bit, all seen on the wire by the controller model. A stuck or wrongly entered state shows on every clock. The per-cycle monitor flags any SDA or SCL drive while the model says the bus is idle, and it measures each SCL hold against the configured length as soon as the hold ends. A false edge from the block's own hold would shift every later bit by one, so it appears by the next acknowledge slot.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_ACK_HOLD,
        ST_PEER_ACK,
        ST_RECV,
        ST_SEND
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e          state;
        logic [CNT_W-1:0]    bit_cnt;
        logic [BYTE_W-1:0]   shreg;
        logic                dir_rd;
        logic                got_data;
        logic                sda_oe;
        logic                rx_valid;
        logic [BYTE_W-1:0]   rx_data;
    } fsm_regs_t;
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic mask,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s,
    output logic scl_level
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_lvl;
        logic              sda_lvl;
    } sync_regs_t;

    sync_regs_t r_d, r_q;
    logic scl_s;

    assign scl_s = r_q.scl_pipe[STAGES-1];
    assign sda_s = r_q.sda_pipe[STAGES-1];
    assign scl_level = r_q.scl_lvl;

    always_comb begin
        r_d = r_q;
        r_d.scl_pipe = {r_q.scl_pipe[STAGES-2:0], scl_i};
        r_d.sda_pipe = {r_q.sda_pipe[STAGES-2:0], sda_i};
        r_d.sda_lvl  = sda_s;
        if (!mask) begin
            r_d.scl_lvl = scl_s;
        end
        scl_rise  = !mask && !r_q.scl_lvl && scl_s;
        scl_fall  = !mask && r_q.scl_lvl && !scl_s;
        start_det = r_q.scl_lvl && scl_s && r_q.sda_lvl && !sda_s;
        stop_det  = r_q.scl_lvl && scl_s && !r_q.sda_lvl && sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{scl_pipe: '1, sda_pipe: '1, scl_lvl: 1'b1, sda_lvl: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/i2ct_stretch.sv
module i2ct_stretch #(
    parameter int CW   = 8,
    parameter int TAIL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trigger,
    input  logic [CW-1:0] len,
    output logic          hold,
    output logic          mask
);
    localparam int TW = $clog2(TAIL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [TW-1:0] tail;
    } str_regs_t;

    str_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (trigger) begin
            r_d.cnt = len;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
        if (r_d.cnt != '0) begin
            r_d.tail = TW'(TAIL);
        end else if (r_q.tail != '0) begin
            r_d.tail = r_q.tail - 1'b1;
        end
        hold = (r_q.cnt != '0);
        mask = (r_q.cnt != '0) || (r_q.tail != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/i2c_const_target.sv
module i2c_const_target
    import i2ct_pkg::*;
#(
    parameter int STRETCH_W   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [BYTE_W-1:0]    cfg_reply,
    input  logic                 cfg_ack_data,
    input  logic [STRETCH_W-1:0] cfg_stretch,
    output logic                 rx_valid,
    output logic [BYTE_W-1:0]    rx_data,
    output logic                 scl_oe,
    output logic                 sda_oe
);
    localparam int MASK_TAIL = SYNC_STAGES + 1;

    fsm_regs_t r_d, r_q;

    logic scl_rise, scl_fall, start_det, stop_det, sda_s, scl_level;
    logic edge_mask, stretch_go;
    logic [BYTE_W-1:0] sh_new, reply_sh;

    i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .mask      (edge_mask),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .scl_level (scl_level)
    );

    assign stretch_go = scl_fall && (r_q.state != ST_IDLE);

    i2ct_stretch #(.CW(STRETCH_W), .TAIL(MASK_TAIL)) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (stretch_go),
        .len     (cfg_stretch),
        .hold    (scl_oe),
        .mask    (edge_mask)
    );

    always_comb begin
        r_d = r_q;
        r_d.rx_valid = 1'b0;
        sh_new   = {r_q.shreg[BYTE_W-2:0], sda_s};
        reply_sh = cfg_reply << r_q.bit_cnt;

        if (start_det) begin
            r_d.state    = ST_ADDR;
            r_d.bit_cnt  = '0;
            r_d.shreg    = '0;
            r_d.got_data = 1'b0;
            r_d.sda_oe   = 1'b0;
        end else if (stop_det) begin
            r_d.state   = ST_IDLE;
            r_d.bit_cnt = '0;
            r_d.shreg   = '0;
            r_d.sda_oe  = 1'b0;
        end else if (scl_rise) begin
            unique case (r_q.state)
                ST_ADDR, ST_RECV: begin
                    r_d.shreg   = sh_new;
                    r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                    if (r_q.bit_cnt == CNT_W'(BYTE_W - 1)) begin
                        r_d.bit_cnt = '0;
                        r_d.shreg   = '0;
                        if (r_q.state == ST_ADDR && sh_new[BYTE_W-1:1] != cfg_addr) begin
                            r_d.state = ST_IDLE;
                        end else begin
                            if (r_q.state == ST_ADDR) begin
                                r_d.dir_rd = sh_new[0];
                            end else begin
                                r_d.rx_valid = 1'b1;
                                r_d.rx_data  = sh_new;
                                r_d.got_data = 1'b1;
                            end
                            r_d.state = ST_ACK;
                        end
                    end
                end
                ST_PEER_ACK: begin
                    r_d.state = sda_s ? ST_IDLE : ST_ACK_HOLD;
                end
                default: ;
            endcase
        end else if (scl_fall) begin
            unique case (r_q.state)
                ST_ACK: begin
                    if (cfg_ack_data || !r_q.got_data) begin
                        r_d.sda_oe = 1'b1;
                    end
                    r_d.state = ST_ACK_HOLD;
                end
                ST_ACK_HOLD, ST_SEND: begin
                    if (r_q.state == ST_ACK_HOLD && !r_q.dir_rd) begin
                        r_d.sda_oe = 1'b0;
                        r_d.state  = ST_RECV;
                    end else if (r_q.bit_cnt == CNT_W'(BYTE_W)) begin
                        r_d.sda_oe  = 1'b0;
                        r_d.bit_cnt = '0;
                        r_d.state   = ST_PEER_ACK;
                    end else begin
                        r_d.sda_oe  = ~reply_sh[BYTE_W-1];
                        r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                        r_d.state   = ST_SEND;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_valid = r_q.rx_valid;
    assign rx_data  = r_q.rx_data;
    assign sda_oe   = r_q.sda_oe;

    // R2: a START always leads into address collection
    a_r2_start_enters_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (r_q.state == ST_ADDR))
        else $error("R2: START did not enter address state");

    // R4: a byte pulse never lasts two cycles
    a_r4_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid)
        else $error("R4: rx_valid longer than one cycle");

    // R6: SDA drive changes only while SCL is seen low
    a_r6_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_level)
        else $error("R6: SDA changed while SCL high");

    // R8: a hold starts only after an SCL fall in an active transaction
    a_r8_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> $past(stretch_go))
        else $error("R8: SCL hold without a qualifying falling edge");

    // R9: no SCL edge is reported while the block itself holds SCL
    a_r9_no_edge_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !(scl_rise || scl_fall))
        else $error("R9: edge detected during own hold");

    // R10: idle means SDA released
    a_r10_idle_sda_free: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> !sda_oe)
        else $error("R10: SDA driven in idle");
endmodule

// File: tb/i2c_const_target_bench.sv
module i2c_const_target_bench;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic scl_ctl = 1'b1, sda_ctl = 1'b1;
    logic [6:0] cfg_addr = 7'h3A;
    logic [7:0] cfg_reply = 8'hC6;
    logic cfg_ack_data = 1'b1;
    logic [7:0] cfg_stretch = 8'd0;
    logic rx_valid, scl_oe, sda_oe;
    logic [7:0] rx_data;
    logic scl_bus, sda_bus;

    assign scl_bus = scl_ctl & ~scl_oe;
    assign sda_bus = sda_ctl & ~sda_oe;

    i2c_const_target u_i2c_const_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .cfg_addr(cfg_addr), .cfg_reply(cfg_reply), .cfg_ack_data(cfg_ack_data),
        .cfg_stretch(cfg_stretch), .rx_valid(rx_valid), .rx_data(rx_data),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int vectors = 0, errors = 0;
    logic quiet = 1'b1;
    int run_len = 0, pulses = 0;
    logic [7:0] got_q[$];

    task automatic check(input logic ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock reference monitor
    always @(negedge clk) begin
        if (rst_n) begin
            check(!(quiet && (sda_oe || scl_oe)), "R10 idle drive", {sda_oe, scl_oe}, 0);
            if (rx_valid) got_q.push_back(rx_data);
            if (scl_oe) run_len++;
            else if (run_len > 0) begin
                check(run_len == int'(cfg_stretch), "R8 hold length", run_len, cfg_stretch);
                pulses++;
                run_len = 0;
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sda_ctl = b; wt(Q);
        scl_ctl = 1'b1; wait_scl_high(); wt(2*Q);
        scl_ctl = 1'b0; wt(Q);
    endtask

    task automatic read_bit(output logic b);
        sda_ctl = 1'b1; wt(Q);
        scl_ctl = 1'b1; wait_scl_high(); wt(Q);
        b = sda_bus; wt(Q);
        scl_ctl = 1'b0; wt(Q);
    endtask

    task automatic do_start();
        quiet = 1'b0;
        sda_ctl = 1'b0; wt(2*Q);
        scl_ctl = 1'b0; wt(Q);
    endtask

    task automatic do_rstart();
        sda_ctl = 1'b1; wt(Q);
        scl_ctl = 1'b1; wait_scl_high(); wt(Q);
        sda_ctl = 1'b0; wt(Q);
        scl_ctl = 1'b0; wt(Q);
    endtask

    task automatic do_stop();
        sda_ctl = 1'b0; wt(Q);
        scl_ctl = 1'b1; wait_scl_high(); wt(Q);
        sda_ctl = 1'b1; wt(2*Q);
        quiet = 1'b1;
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        read_bit(ack);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            read_bit(b);
            v[i] = b;
        end
        send_bit(!give_ack);
    endtask

    task automatic check_rx(input logic [7:0] exp[$], input string req);
        check(got_q.size() == exp.size(), req, got_q.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got_q.size(); i++)
            check(got_q[i] == exp[i], req, got_q[i], exp[i]);
        got_q.delete();
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        logic [7:0] exp_q[$];
        wt(3);
        // R1: reset state
        check(!scl_oe && !sda_oe && !rx_valid, "R1 reset outputs", {scl_oe, sda_oe, rx_valid}, 0);
        rst_n = 1'b1; wt(10);
        check(!scl_oe && !sda_oe && !rx_valid, "R1 after release", {scl_oe, sda_oe, rx_valid}, 0);

        // R3 R4 R5: write two bytes, no stretch
        do_start();
        write_byte({7'h3A, 1'b0}, ack); check(ack == 1'b0, "R3 address ack", ack, 0);
        write_byte(8'hA5, ack); check(ack == 1'b0, "R5 data ack", ack, 0);
        write_byte(8'h3C, ack); check(ack == 1'b0, "R5 data ack", ack, 0);
        do_stop();
        exp_q = '{8'hA5, 8'h3C}; check_rx(exp_q, "R4 write stream");

        // R3 R10: mismatched address ignored, with stretch enabled
        cfg_stretch = 8'd25; pulses = 0;
        do_start();
        for (int i = 7; i >= 0; i--) send_bit(v_bit(8'h2A, i));
        quiet = 1'b1;
        read_bit(ack); check(ack == 1'b1, "R3 mismatch no ack", ack, 1);
        send_bit(1'b0); send_bit(1'b1);
        do_stop();
        exp_q = '{}; check_rx(exp_q, "R3 mismatch no data");
        check(pulses == 8, "R8 holds before mismatch", pulses, 8);

        // R6 R7 R8 R9: read three bytes with stretching
        pulses = 0;
        do_start();
        write_byte({7'h3A, 1'b1}, ack); check(ack == 1'b0, "R3 read address ack", ack, 0);
        read_byte(1'b1, v); check(v == 8'hC6, "R6 reply byte 1", v, 8'hC6);
        read_byte(1'b1, v); check(v == 8'hC6, "R7 reply repeated", v, 8'hC6);
        read_byte(1'b0, v); check(v == 8'hC6, "R9 reply under stretch", v, 8'hC6);
        quiet = 1'b1; wt(4*Q);
        check(pulses == 36, "R8 hold count", pulses, 36);
        do_stop();

        // R5: data bytes not acknowledged but still delivered
        cfg_ack_data = 1'b0; cfg_stretch = 8'd0; cfg_reply = 8'h5B;
        do_start();
        write_byte({7'h3A, 1'b0}, ack); check(ack == 1'b0, "R5 address still acked", ack, 0);
        write_byte(8'h81, ack); check(ack == 1'b1, "R5 data nack", ack, 1);
        write_byte(8'h7E, ack); check(ack == 1'b1, "R5 data nack", ack, 1);
        do_stop();
        exp_q = '{8'h81, 8'h7E}; check_rx(exp_q, "R5 stream kept");

        // R2: repeated START from write to read, with stretch
        cfg_ack_data = 1'b1; cfg_stretch = 8'd13;
        do_start();
        write_byte({7'h3A, 1'b0}, ack);
        write_byte(8'h11, ack); check(ack == 1'b0, "R9 write under stretch", ack, 0);
        do_rstart();
        write_byte({7'h3A, 1'b1}, ack); check(ack == 1'b0, "R2 restart address ack", ack, 0);
        read_byte(1'b0, v); check(v == 8'h5B, "R6 reply after restart", v, 8'h5B);
        quiet = 1'b1; wt(4*Q);
        do_stop();
        exp_q = '{8'h11}; check_rx(exp_q, "R9 stretched byte");

        // R2: START in the middle of an address byte
        cfg_stretch = 8'd0;
        do_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        do_rstart();
        write_byte({7'h3A, 1'b0}, ack); check(ack == 1'b0, "R2 mid-byte restart", ack, 0);
        write_byte(8'hE7, ack);
        do_stop();
        exp_q = '{8'hE7}; check_rx(exp_q, "R2 data after restart");

        wt(20);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    function automatic logic v_bit(input logic [7:0] v, input int i);
        return v[i];
    endfunction
endmodule